// File: doc/BRIEF.md
# LED Dot-Matrix Row Scan Controller

This block refreshes a dot-matrix LED array of 20 columns by 8 rows from a 160-bit dot image. It lights one row at a time, in ascending order, and gives every row an equal slot of 64 scan steps. The 8 slots together form a refresh frame of 512 steps. Each slot opens with a 4-step blanking gap in which every output is off. During that gap the controller captures the columns of the row that is about to light. After the gap, the row sink and the captured column enables are driven for a pulse-width-modulated share of the remaining 60 steps.

Scan steps come from one of two timing sources. The first is an internal divider of the system clock. The second is an external oscillator pin, which passes through a synchroniser and an edge detector. An optional divide-by-8 prescaler can sit between the chosen source and the step counter. The frame needs at least 51.2 kHz of step rate to refresh at 100 Hz or more, which keeps the display free of flicker.

Top module: `led_scan_ctrl`

## Requirements
- R1: While a row is lit, `col_en[c]` equals `dot_image[r*20 + c]`, where r is the row being scanned.
- R2: `row_sel` is all zero or one-hot. Bit r is set only while row r is lit. Rows are scanned in the order 0, 1, …, 7, and row 0 follows row 7.
- R3: A scan position counts steps modulo 512. The row is position / 64, the slot step is position mod 64, and the position wraps from 511 to 0.
- R4: In slot steps 0 to 3 of every row, `row_sel` and `col_en` are all zero.
- R5: With duty d (0 to 15), a row is lit in slot steps 4 to 4+L-1, where L = round(60·d/15) = 4·d. Outside those steps both outputs are zero, and d = 0 keeps the display dark.
- R6: Column data is captured only during the blanking steps of a row. A change of `dot_image` while a row is lit shows from the next row onward.
- R7: With `src_ext` = 0, the position advances once every INT_DIV clocks. After the release of reset, the position after clock edge e is floor(e / INT_DIV). The outputs at edge e reflect the position after edge e-1.
- R8: With `src_ext` = 1, each rising edge of `ext_osc` advances the position by one step, after a two-stage synchroniser. The internal divider then has no effect on the position.
- R9: With `prescale_en` = 1, the position advances on every 8th source tick. After reset, the position after edge e is floor(e / (8·INT_DIV)) for the internal source.
- R10: A synchronous active-high `rst` drives both outputs to zero and returns the position, the divider and the prescaler to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ext | input | 1 | Timing source select: 0 internal divider, 1 external oscillator |
| ext_osc | input | 1 | External oscillator, asynchronous to clk |
| prescale_en | input | 1 | Enables the divide-by-8 prescaler in front of the step counter |
| duty | input | 4 | PWM brightness value, 0 to 15 |
| dot_image | input | 160 | Dot image; bit r*20+c is column c of row r |
| row_sel | output | 8 | One-hot row sink enable, all zero when dark |
| col_en | output | 20 | Column driver enables, all zero when dark |

## Verification
Two functions can act in the same cycle: a new dot image arriving, and the column capture holding its value for the row that is lit. The bench changes every bit of the image in the middle of row 1's lit window. Row 1 must keep its old columns to the end of its window, and row 2 must light with the new pattern. A reference model of the scan position and of the captured row judges every cycle, and it updates its own capture only in blanking steps.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int DEF_COLS      = 20;
    localparam int DEF_ROWS      = 8;
    localparam int DEF_SLOT      = 64;
    localparam int DEF_BLANK     = 4;
    localparam int DEF_DUTY_W    = 4;
    localparam int DEF_PRESCALE  = 8;
    localparam int DEF_INT_DIV   = 4;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } scan_src_e;

    // Rounded share of a window: round(window * duty / duty_max)
    function automatic int lit_length(input int window, input int duty, input int duty_max);
        return (2 * window * duty + duty_max) / (2 * duty_max);
    endfunction

endpackage

// File: rtl/led_scan_tick.sv
module led_scan_tick
    import led_scan_pkg::*;
#(
    parameter int INT_DIV  = DEF_INT_DIV,
    parameter int PRESCALE = DEF_PRESCALE
) (
    input  logic clk,
    input  logic rst,
    input  logic src_ext,
    input  logic ext_osc,
    input  logic prescale_en,
    output logic step_o
);

    localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [2:0]       sync;
        logic [PRE_W-1:0] pre;
    } tick_state_t;

    tick_state_t state_d, state_q;
    logic        int_tick, ext_tick, src_tick, pre_wrap;
    scan_src_e   src_mode;

    always_comb begin
        state_d   = state_q;
        src_mode  = scan_src_e'(src_ext);
        int_tick  = (state_q.div == DIV_W'(INT_DIV - 1));
        state_d.div  = int_tick ? '0 : state_q.div + 1'b1;
        state_d.sync = {state_q.sync[1:0], ext_osc};
        ext_tick  = state_q.sync[1] & ~state_q.sync[2];
        src_tick  = (src_mode == SRC_EXTERNAL) ? ext_tick : int_tick;
        pre_wrap  = (state_q.pre == PRE_W'(PRESCALE - 1));
        if (src_tick) begin
            state_d.pre = pre_wrap ? '0 : state_q.pre + 1'b1;
        end
        step_o = src_tick && (!prescale_en || pre_wrap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R9: with the prescaler on, two steps never come in adjacent cycles
    assert_prescale_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (prescale_en && step_o) |=> !step_o);

endmodule

// File: rtl/led_scan_counter.sv
module led_scan_counter
    import led_scan_pkg::*;
#(
    parameter int NUM_ROWS   = DEF_ROWS,
    parameter int SLOT_STEPS = DEF_SLOT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step_i,
    output logic [$clog2(NUM_ROWS)-1:0]   row_o,
    output logic [$clog2(SLOT_STEPS)-1:0] slot_o
);

    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam int SLOT_W = $clog2(SLOT_STEPS);
    localparam int POS_W = ROW_W + SLOT_W;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step_i) begin
            state_d.pos = state_q.pos + 1'b1;
        end
        row_o  = state_q.pos[POS_W-1:SLOT_W];
        slot_o = state_q.pos[SLOT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R3: the last step of the last row is followed by row 0, step 0
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step_i && (&state_q.pos)) |=> (row_o == '0 && slot_o == '0));

endmodule

// File: rtl/led_scan_row_latch.sv
module led_scan_row_latch
    import led_scan_pkg::*;
#(
    parameter int NUM_COLS = DEF_COLS,
    parameter int NUM_ROWS = DEF_ROWS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_i,
    input  logic [$clog2(NUM_ROWS)-1:0]   row_i,
    input  logic [NUM_COLS*NUM_ROWS-1:0]  dot_image,
    output logic [NUM_COLS-1:0]           cols_o
);

    typedef struct packed {
        logic [NUM_COLS-1:0] cols;
    } latch_state_t;

    latch_state_t        state_d, state_q;
    logic [NUM_COLS-1:0] row_bits;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign row_bits[c] = dot_image[int'(row_i) * NUM_COLS + c];
    end

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.cols = row_bits;
        end
        cols_o = state_q.cols;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R6: outside blanking the captured row never changes
    assert_hold_outside_blank_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cols_o));

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
    import led_scan_pkg::*;
#(
    parameter int NUM_COLS     = DEF_COLS,
    parameter int NUM_ROWS     = DEF_ROWS,
    parameter int SLOT_STEPS   = DEF_SLOT,
    parameter int BLANK_STEPS  = DEF_BLANK,
    parameter int DUTY_W       = DEF_DUTY_W,
    parameter int PRESCALE     = DEF_PRESCALE,
    parameter int INT_DIV      = DEF_INT_DIV
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          src_ext,
    input  logic                          ext_osc,
    input  logic                          prescale_en,
    input  logic [DUTY_W-1:0]             duty,
    input  logic [NUM_COLS*NUM_ROWS-1:0]  dot_image,
    output logic [NUM_ROWS-1:0]           row_sel,
    output logic [NUM_COLS-1:0]           col_en
);

    localparam int ROW_W    = $clog2(NUM_ROWS);
    localparam int SLOT_W   = $clog2(SLOT_STEPS);
    localparam int WINDOW   = SLOT_STEPS - BLANK_STEPS;
    localparam int DUTY_MAX = (1 << DUTY_W) - 1;

    typedef struct packed {
        logic [NUM_ROWS-1:0] row_sel;
        logic [NUM_COLS-1:0] col_en;
    } out_state_t;

    logic                step;
    logic [ROW_W-1:0]    cur_row;
    logic [SLOT_W-1:0]   cur_slot;
    logic                in_blank;
    logic                lit;
    logic [NUM_COLS-1:0] held_cols;
    int                  on_len;
    out_state_t          out_d, out_q;

    led_scan_tick #(
        .INT_DIV  (INT_DIV),
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk         (clk),
        .rst         (rst),
        .src_ext     (src_ext),
        .ext_osc     (ext_osc),
        .prescale_en (prescale_en),
        .step_o      (step)
    );

    led_scan_counter #(
        .NUM_ROWS   (NUM_ROWS),
        .SLOT_STEPS (SLOT_STEPS)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .row_o  (cur_row),
        .slot_o (cur_slot)
    );

    assign in_blank = (int'(cur_slot) < BLANK_STEPS);

    led_scan_row_latch #(
        .NUM_COLS (NUM_COLS),
        .NUM_ROWS (NUM_ROWS)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load_i    (in_blank),
        .row_i     (cur_row),
        .dot_image (dot_image),
        .cols_o    (held_cols)
    );

    always_comb begin
        out_d  = '0;
        on_len = lit_length(WINDOW, int'(duty), DUTY_MAX);
        lit    = !in_blank && ((int'(cur_slot) - BLANK_STEPS) < on_len);
        if (lit) begin
            out_d.row_sel = NUM_ROWS'(1) << cur_row;
            out_d.col_en  = held_cols;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign row_sel = out_q.row_sel;
    assign col_en  = out_q.col_en;

    // R2: at most one row sink on at a time
    assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

    // R4: a blanking step yields dark outputs one clock later
    assert_blank_dark_R4: assert property (@(posedge clk) disable iff (rst)
        in_blank |=> (row_sel == '0 && col_en == '0));

    // R4: columns are never driven without a row
    assert_cols_need_row_R4: assert property (@(posedge clk) disable iff (rst)
        (row_sel == '0) |-> (col_en == '0));

    // R5: a zero duty value leaves the array dark
    assert_duty_zero_dark_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(duty) == '0) |-> (row_sel == '0));

    // R6: columns stay fixed through an unbroken lit run
    assert_lit_cols_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (row_sel != '0 && $past(row_sel) != '0) |-> (col_en == $past(col_en)));

    // R10: reset darkens the outputs
    assert_reset_dark_R10: assert property (@(posedge clk)
        rst |=> (row_sel == '0 && col_en == '0));

endmodule

// File: tb/led_scan_ctrl_bench.sv
`timescale 1ns/1ps
module led_scan_ctrl_bench;

    localparam int COLS  = 20;
    localparam int ROWS  = 8;
    localparam int SLOT  = 64;
    localparam int BLANK = 4;
    localparam int DIV   = 2;
    localparam int FRAME = ROWS * SLOT;

    typedef struct {
        logic [ROWS-1:0] row;
        logic [COLS-1:0] col;
        string           tag;
    } exp_item_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 src_ext = 1'b0;
    logic                 ext_osc = 1'b0;
    logic                 prescale_en = 1'b0;
    logic [3:0]           duty = 4'd0;
    logic [COLS*ROWS-1:0] dot_image = '0;
    logic [ROWS-1:0]      row_sel;
    logic [COLS-1:0]      col_en;

    int        checks = 0;
    int        failures = 0;
    bit        done = 1'b0;
    exp_item_t exp_q[$];

    always #4 clk = ~clk;

    led_scan_ctrl #(
        .NUM_COLS    (COLS),
        .NUM_ROWS    (ROWS),
        .SLOT_STEPS  (SLOT),
        .BLANK_STEPS (BLANK),
        .DUTY_W      (4),
        .PRESCALE    (8),
        .INT_DIV     (DIV)
    ) u_led_scan_ctrl (
        .clk         (clk),
        .rst         (rst),
        .src_ext     (src_ext),
        .ext_osc     (ext_osc),
        .prescale_en (prescale_en),
        .duty        (duty),
        .dot_image   (dot_image),
        .row_sel     (row_sel),
        .col_en      (col_en)
    );

    function automatic logic [COLS-1:0] image_row(logic [COLS*ROWS-1:0] img, int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = img[r*COLS + c];
        return v;
    endfunction

    task automatic check(string tag, logic [ROWS-1:0] act_r, logic [COLS-1:0] act_c,
                         logic [ROWS-1:0] exp_r, logic [COLS-1:0] exp_c);
        checks++;
        if (act_r !== exp_r || act_c !== exp_c) begin
            failures++;
            $display("FAIL %s actual row=%b col=%h expected row=%b col=%h",
                     tag, act_r, act_c, exp_r, exp_c);
        end
    endtask

    // Monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            check(it.tag, row_sel, col_en, it.row, it.col);
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset state", row_sel, col_en, '0, '0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // Driver: internal source, steps every period clocks (R7, R9)
    task automatic run_internal(int period, int nclk, int duty_v, int change_at, string tag);
        int              m_pos = 0;
        logic [COLS-1:0] m_latch = '0;
        for (int e = 1; e <= nclk; e++) begin
            exp_item_t it;
            int        slot = m_pos % SLOT;
            int        row  = m_pos / SLOT;
            int        on   = (2 * 60 * duty_v + 15) / 30;
            bit        lit;
            @(posedge clk);
            lit    = (slot >= BLANK) && (slot - BLANK < on);
            it.row = lit ? (ROWS'(1) << row) : '0;
            it.col = lit ? m_latch : '0;
            it.tag = $sformatf("%s pos=%0d", tag, m_pos);
            exp_q.push_back(it);
            if (slot < BLANK) m_latch = image_row(dot_image, row);
            m_pos = (e / period) % FRAME;
            #1;
            if (e == change_at) dot_image = ~dot_image;
        end
        @(negedge clk);
    endtask

    task automatic ext_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_osc = 1'b1;
            repeat (3) @(posedge clk);
            #1;
            ext_osc = 1'b0;
            repeat (3) @(posedge clk);
            #1;
        end
        repeat (6) @(posedge clk);
    endtask

    logic [COLS*ROWS-1:0] base_img;

    initial begin
        for (int i = 0; i < COLS*ROWS; i++) base_img[i] = (((i * 37 + 11) % 7) < 3);

        // R1 R3 R6 R7: full duty, frame wrap, image flipped in row 1 slot 30
        dot_image = base_img; duty = 4'd15; prescale_en = 1'b0; src_ext = 1'b0;
        do_reset();
        run_internal(DIV, 1100, 15, 2 * (SLOT + 30), "R1/R3/R6/R7 duty15");

        // R5: duty zero keeps everything dark
        dot_image = base_img; duty = 4'd0;
        do_reset();
        run_internal(DIV, 1030, 0, -1, "R5 duty0");

        // R5 R4 R2: partial duty, lit steps 4..23
        duty = 4'd5;
        do_reset();
        run_internal(DIV, 1030, 5, -1, "R5/R4/R2 duty5");

        // R9: prescaler divides the step rate by 8
        duty = 4'd15; prescale_en = 1'b1;
        do_reset();
        run_internal(8 * DIV, 3200, 15, -1, "R9 prescale");

        // R8: external source
        prescale_en = 1'b0; src_ext = 1'b1; duty = 4'd15; dot_image = base_img;
        do_reset();
        ext_pulses(70);
        @(negedge clk);
        check("R8 ext pos70", row_sel, col_en, 8'b0000_0010, image_row(base_img, 1));
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R8 ext idle hold", row_sel, col_en, 8'b0000_0010, image_row(base_img, 1));
        @(posedge clk); #1;
        ext_pulses(60);
        @(negedge clk);
        check("R8/R4 ext pos130 blank", row_sel, col_en, '0, '0);
        @(posedge clk); #1;
        ext_pulses(2);
        @(negedge clk);
        check("R8/R2 ext pos132", row_sel, col_en, 8'b0000_0100, image_row(base_img, 2));

        // R10: reset mid-frame returns to row 0, step 0 (dark blank)
        rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        check("R10 mid-run reset", row_sel, col_en, '0, '0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule